// File: doc/BRIEF.md
# Quad-Channel FIFO Ready Reporter

This block watches the fill levels of four UART channels. Each channel has a 128-entry transmit FIFO and a 128-entry receive FIFO. The block turns those levels into one 8-bit ready word that refreshes every clock. The low nibble tells, per channel, whether the transmit FIFO can take another byte. The high nibble tells, per channel, whether the receive side is at or under its programmed trigger level and has not timed out.

The fill counts and timeout flags are registered once on entry. The ready word is combinational from those registered values, so nothing is latched on a read.

A small register window of four byte addresses sits alongside the ready word:
- A control byte picks one of four trigger tables and one of four levels inside that table.
- The same control byte holds a readback mode bit, a transmit/receive direction bit and a channel index.
- In normal mode the scratch address is a plain read/write byte.
- In count mode the scratch address returns the selected channel's FIFO occupancy instead, saturated at 128.

Top module: `quad_fifo_status`

## Requirements
- R1: Ready bit c (c = 0..3, channel c) is 1 when the registered transmit count of channel c is below 128 and 0 otherwise, counts of 128 or more included; it follows the fill input one clock later.
- R2: Ready bit 4+c is 1 when channel c's registered receive count is less than or equal to the active receive trigger level and its registered timeout flag is 0, else 0; one clock latency.
- R3: After reset the control byte and scratch byte read 0, the registered counts and timeouts are 0, and the ready word is 8'hFF.
- R4: The active receive trigger level is (lvl+1) * (128 >> (5 - tbl)) for table field tbl and level field lvl. Table 0 gives 4..16, table 3 gives 32..128. The transmit level is 128 minus that value. Address 3 reads the transmit level when the direction bit is 1 and the receive level otherwise.
- R5: Address 0 is the control byte, written and read back whole, with layout [7:6] channel, [5] count mode, [4] direction (1 = transmit), [3:2] level, [1:0] table.
- R6: With count mode 0, address 1 is a general byte: a write is read back unchanged.
- R7: With count mode 1, a read of address 1 returns the selected channel's registered transmit or receive count, saturated at 128.
- R8: With count mode 1, writes to address 1 are ignored: the earlier scratch value reads back once count mode returns to 0.
- R9: Address 2 reads the current ready word, equal to the ready output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_fill_i | input | 32 | Transmit fill counts, channel c in bits [8c+7:8c] |
| rx_fill_i | input | 32 | Receive fill counts, channel c in bits [8c+7:8c] |
| rx_tmo_i | input | 4 | Receive timeout flag per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| ready_o | output | 8 | Ready word: transmit room [3:0], receive ready [7:4] |

## Verification
The ready word and the count readback both settle one clock after a change on the fill or timeout inputs. A register write takes effect at the edge where the strobe is sampled, and a read of any address is valid in the same cycle the address is presented. The driver changes inputs just after a falling edge, waits for the rising edge that captures them, and then queues the expected value. The monitor compares that value at the following falling edge, so every check lands exactly one register stage after its stimulus.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_SCR  = 2'd1;
   localparam logic [1:0] ADR_STAT = 2'd2;
   localparam logic [1:0] ADR_TRIG = 2'd3;

   typedef struct packed {
      logic [1:0] chan;
      logic       cnt_mode;
      logic       tx_dir;
      logic [1:0] lvl;
      logic [1:0] tbl;
   } ctrl_t;

   // receive trigger level for a table/level pair
   function automatic int unsigned rx_level(input int unsigned tbl,
                                            input int unsigned lvl,
                                            input int unsigned depth);
      return (lvl + 1) * (depth >> (5 - tbl));
   endfunction

endpackage

// File: rtl/qfs_trig_table.sv
module qfs_trig_table #(
   parameter int DEPTH = 128,
   parameter int CW    = 8
) (
   input  logic [1:0]    tbl_i,
   input  logic [1:0]    lvl_i,
   output logic [CW-1:0] rx_lvl_o,
   output logic [CW-1:0] tx_lvl_o
);
   localparam int NTBL = 4;
   localparam int NLVL = 4;
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] rx_lut [NTBL*NLVL];

   for (genvar t = 0; t < NTBL; t++) begin : g_tbl
      for (genvar l = 0; l < NLVL; l++) begin : g_lvl
         assign rx_lut[t*NLVL + l] = CW'(qfs_pkg::rx_level(t, l, DEPTH));
      end
   end

   assign rx_lvl_o = rx_lut[{tbl_i, lvl_i}];
   assign tx_lvl_o = FULL - rx_lvl_o;

endmodule

// File: rtl/qfs_chan_status.sv
module qfs_chan_status #(
   parameter int DEPTH = 128,
   parameter int CW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] tx_fill_i,
   input  logic [CW-1:0] rx_fill_i,
   input  logic          rx_tmo_i,
   input  logic [CW-1:0] rx_lvl_i,
   output logic          tx_rdy_o,
   output logic          rx_rdy_o,
   output logic [CW-1:0] tx_cnt_o,
   output logic [CW-1:0] rx_cnt_o
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] tx_q, rx_q;
   logic          tmo_q;

   function automatic logic [CW-1:0] clip(input logic [CW-1:0] v);
      return (v > FULL) ? FULL : v;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q  <= '0;
         rx_q  <= '0;
         tmo_q <= 1'b0;
      end else begin
         tx_q  <= clip(tx_fill_i);
         rx_q  <= clip(rx_fill_i);
         tmo_q <= rx_tmo_i;
      end
   end

   assign tx_rdy_o = (tx_q < FULL);
   assign rx_rdy_o = !tmo_q && (rx_q <= rx_lvl_i);
   assign tx_cnt_o = tx_q;
   assign rx_cnt_o = rx_q;

   // R1: a full (or over-full) fill sampled last cycle clears transmit room
   assert_tx_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ($past(tx_fill_i) >= FULL) |-> !tx_rdy_o);
   assert_tx_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ($past(tx_fill_i) < FULL) |-> tx_rdy_o);
   // R2: a timeout sampled last cycle forces receive not ready
   assert_rx_tmo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(rx_tmo_i) |-> !rx_rdy_o);
   // R7: the registered count never exceeds the FIFO depth
   assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt_o <= FULL) && (rx_cnt_o <= FULL));

endmodule

// File: rtl/qfs_regs.sv
module qfs_regs #(
   parameter int NCH   = 4,
   parameter int DEPTH = 128,
   parameter int CW    = 8,
   parameter int DW    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [1:0]          addr_i,
   input  logic [DW-1:0]       wdata_i,
   input  logic [2*NCH-1:0]    ready_i,
   input  logic [NCH*CW-1:0]   tx_cnt_i,
   input  logic [NCH*CW-1:0]   rx_cnt_i,
   input  logic [CW-1:0]       rx_lvl_i,
   input  logic [CW-1:0]       tx_lvl_i,
   output qfs_pkg::ctrl_t      ctrl_o,
   output logic [DW-1:0]       rdata_o
);
   import qfs_pkg::*;

   ctrl_t         ctrl_q;
   logic [DW-1:0] scr_q;
   logic [CW-1:0] cnt_sel;
   int unsigned   idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         scr_q  <= '0;
      end else if (we_i) begin
         if (addr_i == ADR_CTRL) ctrl_q <= ctrl_t'(wdata_i);
         if (addr_i == ADR_SCR && !ctrl_q.cnt_mode) scr_q <= wdata_i;
      end
   end

   always_comb begin
      idx     = int'(ctrl_q.chan);
      cnt_sel = ctrl_q.tx_dir ? tx_cnt_i[idx*CW +: CW] : rx_cnt_i[idx*CW +: CW];
   end

   always_comb begin
      unique case (addr_i)
         ADR_CTRL: rdata_o = DW'(ctrl_q);
         ADR_SCR:  rdata_o = ctrl_q.cnt_mode ? DW'(cnt_sel) : scr_q;
         ADR_STAT: rdata_o = DW'(ready_i);
         default:  rdata_o = ctrl_q.tx_dir ? DW'(tx_lvl_i) : DW'(rx_lvl_i);
      endcase
   end

   assign ctrl_o = ctrl_q;

   // R8: a scratch write while in count mode leaves the scratch byte alone
   assert_scr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.cnt_mode && we_i && (addr_i == ADR_SCR) |=> $stable(scr_q));
   // R7: count readback stays within the FIFO depth
   assert_cnt_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.cnt_mode && (addr_i == ADR_SCR) |-> (rdata_o <= DW'(DEPTH)));

endmodule

// File: rtl/quad_fifo_status.sv
module quad_fifo_status #(
   parameter int NCH   = 4,
   parameter int DEPTH = 128,
   parameter int DW    = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NCH*$clog2(DEPTH+1)-1:0]      tx_fill_i,
   input  logic [NCH*$clog2(DEPTH+1)-1:0]      rx_fill_i,
   input  logic [NCH-1:0]                      rx_tmo_i,
   input  logic                                reg_we_i,
   input  logic [1:0]                          reg_addr_i,
   input  logic [DW-1:0]                       reg_wdata_i,
   output logic [DW-1:0]                       reg_rdata_o,
   output logic [2*NCH-1:0]                    ready_o
);
   localparam int CW = $clog2(DEPTH + 1);

   if (NCH != 4) begin : g_bad_nch
      $error("quad_fifo_status: NCH must be 4 (2-bit channel field)");
   end
   if (DW != 8) begin : g_bad_dw
      $error("quad_fifo_status: DW must be 8 (byte control layout)");
   end
   if ((DEPTH % 32) != 0 || CW > DW) begin : g_bad_depth
      $error("quad_fifo_status: DEPTH must be a multiple of 32 and fit DW");
   end

   qfs_pkg::ctrl_t    ctrl;
   logic [CW-1:0]     rx_lvl, tx_lvl;
   logic [NCH*CW-1:0] tx_cnt, rx_cnt;
   logic [NCH-1:0]    tx_rdy, rx_rdy;

   qfs_trig_table #(.DEPTH(DEPTH), .CW(CW)) u_trig (
      .tbl_i    (ctrl.tbl),
      .lvl_i    (ctrl.lvl),
      .rx_lvl_o (rx_lvl),
      .tx_lvl_o (tx_lvl)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      qfs_chan_status #(.DEPTH(DEPTH), .CW(CW)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tx_fill_i (tx_fill_i[c*CW +: CW]),
         .rx_fill_i (rx_fill_i[c*CW +: CW]),
         .rx_tmo_i  (rx_tmo_i[c]),
         .rx_lvl_i  (rx_lvl),
         .tx_rdy_o  (tx_rdy[c]),
         .rx_rdy_o  (rx_rdy[c]),
         .tx_cnt_o  (tx_cnt[c*CW +: CW]),
         .rx_cnt_o  (rx_cnt[c*CW +: CW])
      );
   end

   assign ready_o = {rx_rdy, tx_rdy};

   qfs_regs #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (reg_we_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .ready_i  (ready_o),
      .tx_cnt_i (tx_cnt),
      .rx_cnt_i (rx_cnt),
      .rx_lvl_i (rx_lvl),
      .tx_lvl_i (tx_lvl),
      .ctrl_o   (ctrl),
      .rdata_o  (reg_rdata_o)
   );

   // R4: the active receive level is nonzero and within the FIFO depth
   assert_lvl_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_lvl != '0) && (rx_lvl <= CW'(DEPTH)));
   // R9: the status address mirrors the ready output
   assert_stat_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == qfs_pkg::ADR_STAT) |-> (reg_rdata_o == DW'(ready_o)));

endmodule

// File: tb/quad_fifo_status_bench.sv
`timescale 1ns/1ps
module quad_fifo_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tx_fill = '0;
   logic [31:0] rx_fill = '0;
   logic [3:0]  rx_tmo = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [7:0]  ready;

   always #4 clk = ~clk;

   quad_fifo_status u_quad_fifo_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_fill_i   (tx_fill),
      .rx_fill_i   (rx_fill),
      .rx_tmo_i    (rx_tmo),
      .reg_we_i    (reg_we),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .ready_o     (ready)
   );

   typedef struct {
      bit         is_rd;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sbq[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // bench model
   int       tx_m[4];
   int       rx_m[4];
   bit [3:0] tmo_m;
   bit [7:0] ctrl_m;
   bit [7:0] scr_m;

   function automatic int rx_lvl_m();
      int tbl = ctrl_m[1:0];
      int lvl = ctrl_m[3:2];
      return (lvl + 1) * (128 >> (5 - tbl));
   endfunction

   function automatic logic [7:0] ready_m();
      logic [7:0] r;
      for (int c = 0; c < 4; c++) begin
         r[c]   = (tx_m[c] < 128);
         r[c+4] = (rx_m[c] <= rx_lvl_m()) && !tmo_m[c];
      end
      return r;
   endfunction

   function automatic int sat_m(input int v);
      return (v > 128) ? 128 : v;
   endfunction

   function automatic logic [7:0] cbyte(input int chan, input int mode,
                                        input int dir, input int lvl,
                                        input int tbl);
      return {2'(chan), 1'(mode), 1'(dir), 2'(lvl), 2'(tbl)};
   endfunction

   // monitor: compare queued expectations at the falling edge
   always @(negedge clk) begin
      item_t      it;
      logic [7:0] act;
      while (sbq.size() > 0) begin
         it  = sbq.pop_front();
         act = it.is_rd ? reg_rdata : ready;
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
         end
      end
   end

   task automatic push(input bit is_rd, input logic [7:0] exp, input string req);
      item_t it;
      it.is_rd = is_rd;
      it.exp   = exp;
      it.req   = req;
      sbq.push_back(it);
   endtask

   task automatic drive_fills();
      @(negedge clk); #1;
      for (int c = 0; c < 4; c++) begin
         tx_fill[c*8 +: 8] = 8'(tx_m[c]);
         rx_fill[c*8 +: 8] = 8'(rx_m[c]);
      end
      rx_tmo = tmo_m;
      @(posedge clk); #1;
   endtask

   task automatic chk_ready(input string req);
      push(1'b0, ready_m(), req);
      @(negedge clk); #1;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
      if (a == 2'd0) ctrl_m = d;
      if (a == 2'd1 && !ctrl_m[5]) scr_m = d;
   endtask

   task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); #1;
      reg_addr = a;
      @(posedge clk); #1;
      push(1'b1, exp, req);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) begin tx_m[c] = 0; rx_m[c] = 0; end
      tmo_m = '0; ctrl_m = '0; scr_m = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R3 reset state
      @(posedge clk); #1;
      chk_ready("R3 ready after reset");
      chk_rd(2'd0, 8'h00, "R3 control after reset");
      chk_rd(2'd1, 8'h00, "R3 scratch after reset");
      chk_rd(2'd3, 8'd4,  "R4 table0 level0 receive");

      // R1 transmit room, boundaries 127/128/over-full
      tx_m = '{0, 128, 127, 200};
      drive_fills();
      chk_ready("R1 tx full/room pattern");

      // R2 receive threshold and timeout
      rx_m = '{4, 5, 3, 0};
      tmo_m = 4'b0100;
      drive_fills();
      chk_ready("R2 rx trigger boundary and timeout");

      // R5 control write/readback, R4 table 3 level 3 = 128
      reg_write(2'd0, cbyte(0, 0, 0, 3, 3));
      chk_rd(2'd0, ctrl_m, "R5 control readback");
      chk_rd(2'd3, 8'd128, "R4 table3 level3 receive");
      rx_m = '{100, 128, 127, 0};
      drive_fills();
      chk_ready("R2 rx under widest level");

      // R4 table 1 level 2, both directions
      reg_write(2'd0, cbyte(0, 0, 0, 2, 1));
      chk_rd(2'd3, 8'd24, "R4 table1 level2 receive");
      chk_ready("R2 rx against level 24");
      reg_write(2'd0, cbyte(0, 0, 1, 2, 1));
      chk_rd(2'd3, 8'd104, "R4 table1 level2 transmit");

      // R9 status address
      tmo_m = 4'b0000;
      drive_fills();
      chk_rd(2'd2, ready_m(), "R9 status address view");

      // R6 scratch in normal mode
      reg_write(2'd1, 8'hA5);
      chk_rd(2'd1, 8'hA5, "R6 scratch readback");

      // R7 count readback, saturation
      reg_write(2'd0, cbyte(3, 1, 1, 0, 0));
      chk_rd(2'd1, 8'(sat_m(tx_m[3])), "R7 tx count ch3 saturated");
      reg_write(2'd0, cbyte(2, 1, 0, 0, 0));
      chk_rd(2'd1, 8'(sat_m(rx_m[2])), "R7 rx count ch2");
      rx_m[1] = 250;
      drive_fills();
      reg_write(2'd0, cbyte(1, 1, 0, 0, 0));
      chk_rd(2'd1, 8'(sat_m(rx_m[1])), "R7 rx count ch1 saturated");

      // R8 scratch write ignored in count mode
      reg_write(2'd1, 8'h3C);
      chk_rd(2'd1, 8'(sat_m(rx_m[1])), "R8 count still shown after write");
      reg_write(2'd0, cbyte(1, 0, 0, 0, 0));
      chk_rd(2'd1, 8'hA5, "R8 scratch kept");

      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule